// File: doc/BRIEF.md
# Occupancy-Threshold Bundle Splitter

This block sits between instruction fetch and the lanes of an eight-slot wide-issue pipeline. The lanes are paired statically: lane i+4 can re-execute the instruction of lane i so that a comparator can check the two results. A bundle that leaves all four upper slots empty is therefore fully protected at no cost. A bundle that fills the upper half leaves some lower slots without a partner.

The block keeps a running measure of how crowded the upper half has been. The measure covers only the bundles that place something in slots 4 to 7. When that measure reaches a programmable threshold, the current crowded bundle is issued as two consecutive transfers of at most four instructions each. Both transfers are marked for full pairing. While the second transfer is pending, fetch is stalled.

Lowering the threshold buys coverage at the price of extra cycles. Raising it does the reverse.

Top module: `bsplit_top`

## Requirements
- R1: After reset the threshold register holds 4, meaning 1.0 in quarter units, and both statistic counters are zero. No transfer is pending, `fetch_stall` is 0, and `out_valid` is 0 while `in_valid` is 0. A qualifying bundle that arrives straight after reset is split.
- R2: A bundle with `in_used[7:4]` all zero is non-qualifying. It is issued unchanged in one transfer, with `out_used`/`out_insn` equal to the input, `out_dup` = 4'b1111 and `out_second` = 0. It leaves the statistic untouched.
- R3: A qualifying bundle that is not split is issued whole in one transfer. In that transfer `out_dup[i]` = NOT `in_used[i+4]`, so each idle upper lane checks its lower partner.
- R4: For each accepted qualifying bundle, the sum S gains the number of set bits in `in_used[7:4]` and the count C gains 1. The current bundle is included before the decision. The bundle is split when 4*S >= T*C, where T is the threshold register.
- R5: `thr_wdata` is an unsigned threshold with 2 fractional bits. For example, 7 means 1.75, 9 means 2.25 and 15 means 3.75.
- R6: A split issues two transfers. The first carries input lanes 0-3 in output lanes 0-3, with lanes 4-7 holding zero data and zero `out_used`, and `out_second` = 0. The second carries input lanes 4-7 moved into output lanes 0-3, with `out_second` = 1. Both transfers have `out_dup` = 4'b1111.
- R7: While the second transfer is pending, `fetch_stall` = 1, `in_ready` = 0 and `out_valid` = 1. The output stays unchanged until `out_ready` is seen.
- R8: A write with `thr_we` = 1 loads the threshold and clears S and C. The next bundle is judged against the new threshold and a fresh statistic.
- R9: When no transfer is pending, `in_ready` equals `out_ready`. A bundle offered while `out_ready` = 0 is not accepted and does not change the statistic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold, 2 fractional bits |
| in_valid | input | 1 | Bundle offered by fetch |
| in_ready | output | 1 | Bundle accepted this cycle when high with in_valid |
| in_used | input | 8 | Per-slot occupancy, 1 = real instruction |
| in_insn | input | 256 | Eight 32-bit instruction slots, slot 0 in the low bits |
| out_valid | output | 1 | Transfer offered to the lanes |
| out_ready | input | 1 | Lanes take the transfer |
| out_used | output | 8 | Occupancy of the main slots in the transfer |
| out_insn | output | 256 | Instruction slots of the transfer |
| out_dup | output | 4 | Bit i: lane i+4 re-executes lane i |
| out_second | output | 1 | Transfer is the upper half of a split bundle |
| fetch_stall | output | 1 | Fetch must hold while the second half is pending |

## Verification
The properties assume that fetch keeps a bundle stable while it is offered and not yet accepted. They also assume that a threshold write never coincides with an accepted bundle. The stimulus drives every input one half period before the active edge. It changes a held bundle only after it sees `in_ready` high or after it withdraws `in_valid`. It issues threshold writes only in cycles with `in_valid` low. Under these conditions the pass-through, pairing and stall relations can be stated purely in terms of the ports, one cycle at a time.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    localparam int BS_SLOTS = 8;
    localparam int BS_IW    = 32;
    localparam int BS_TW    = 8;
    localparam int BS_CW    = 32;
    localparam int BS_FRAC  = 2;

    // Kind of transfer presented at the output
    typedef enum logic [1:0] {
        XFER_WHOLE = 2'd0,
        XFER_LOW   = 2'd1,
        XFER_HIGH  = 2'd2
    } xfer_e;

    // Saturating increment helper for a 32-bit counter
    function automatic logic [BS_CW-1:0] sat_add(input logic [BS_CW-1:0] a,
                                                 input logic [BS_CW-1:0] b);
        logic [BS_CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BS_CW] ? {BS_CW{1'b1}} : s[BS_CW-1:0];
    endfunction

endpackage

// File: rtl/bsplit_stats.sv
module bsplit_stats
    import bsplit_pkg::*;
#(
    parameter int HALF = 4,
    parameter int TW   = BS_TW,
    parameter int FRAC = BS_FRAC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        thr_we,
    input  logic [TW-1:0]               thr_wdata,
    input  logic                        qual,
    input  logic [$clog2(HALF+1)-1:0]   ucnt,
    input  logic                        accept,
    output logic                        split
);

    localparam int CW      = BS_CW;
    localparam int PW      = CW + TW + FRAC;
    localparam int THR_ONE = 1 << FRAC;

    logic [TW-1:0] thr_q;
    logic [CW-1:0] sum_q, cnt_q;
    logic [CW-1:0] sum_nx, cnt_nx;
    logic [PW-1:0] lhs, rhs;

    always_comb begin
        sum_nx = sat_add(sum_q, CW'(ucnt));
        cnt_nx = sat_add(cnt_q, CW'(1));
        lhs    = PW'(sum_nx) << FRAC;
        rhs    = PW'(thr_q) * PW'(cnt_nx);
        split  = qual && (lhs >= rhs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= TW'(THR_ONE);
            sum_q <= '0;
            cnt_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
            sum_q <= '0;
            cnt_q <= '0;
        end else if (accept && qual) begin
            sum_q <= sum_nx;
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/bsplit_issue.sv
module bsplit_issue
    import bsplit_pkg::*;
#(
    parameter int SLOTS = BS_SLOTS,
    parameter int IW    = BS_IW,
    parameter int HALF  = SLOTS / 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SLOTS-1:0]      in_used,
    input  logic [SLOTS*IW-1:0]   in_insn,
    input  logic                  split,
    output logic                  accept,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SLOTS-1:0]      out_used,
    output logic [SLOTS*IW-1:0]   out_insn,
    output logic [HALF-1:0]       out_dup,
    output logic                  out_second,
    output logic                  fetch_stall
);

    localparam int LW = HALF * IW;

    logic            pend_q;
    logic [HALF-1:0] hi_used_q;
    logic [LW-1:0]   hi_insn_q;
    xfer_e           xfer;

    always_comb begin
        if (pend_q)     xfer = XFER_HIGH;
        else if (split) xfer = XFER_LOW;
        else            xfer = XFER_WHOLE;

        in_ready    = out_ready && !pend_q;
        out_valid   = pend_q || in_valid;
        fetch_stall = pend_q;
        accept      = in_valid && in_ready;

        case (xfer)
            XFER_HIGH: begin
                out_used   = {{HALF{1'b0}}, hi_used_q};
                out_insn   = {{LW{1'b0}}, hi_insn_q};
                out_dup    = '1;
                out_second = 1'b1;
            end
            XFER_LOW: begin
                out_used   = {{HALF{1'b0}}, in_used[HALF-1:0]};
                out_insn   = {{LW{1'b0}}, in_insn[LW-1:0]};
                out_dup    = '1;
                out_second = 1'b0;
            end
            default: begin
                out_used   = in_used;
                out_insn   = in_insn;
                out_dup    = ~in_used[SLOTS-1:HALF];
                out_second = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            hi_used_q <= '0;
            hi_insn_q <= '0;
        end else if (pend_q) begin
            if (out_ready) pend_q <= 1'b0;
        end else if (accept && split) begin
            pend_q    <= 1'b1;
            hi_used_q <= in_used[SLOTS-1:HALF];
            hi_insn_q <= in_insn[SLOTS*IW-1:LW];
        end
    end

endmodule

// File: rtl/bsplit_top.sv
module bsplit_top
    import bsplit_pkg::*;
#(
    parameter int SLOTS = BS_SLOTS,
    parameter int IW    = BS_IW,
    parameter int TW    = BS_TW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          thr_we,
    input  logic [TW-1:0]                 thr_wdata,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [SLOTS-1:0]              in_used,
    input  logic [SLOTS*IW-1:0]           in_insn,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [SLOTS-1:0]              out_used,
    output logic [SLOTS*IW-1:0]           out_insn,
    output logic [SLOTS/2-1:0]            out_dup,
    output logic                          out_second,
    output logic                          fetch_stall
);

    localparam int HALF = SLOTS / 2;
    localparam int UCW  = $clog2(HALF + 1);

    logic           qual;
    logic [UCW-1:0] ucnt;
    logic           split;
    logic           accept;

    always_comb begin
        qual = |in_used[SLOTS-1:HALF];
        ucnt = UCW'($countones(in_used[SLOTS-1:HALF]));
    end

    bsplit_stats #(
        .HALF (HALF),
        .TW   (TW),
        .FRAC (BS_FRAC)
    ) stats_i (
        .clk       (clk),
        .rst       (rst),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .qual      (qual),
        .ucnt      (ucnt),
        .accept    (accept),
        .split     (split)
    );

    bsplit_issue #(
        .SLOTS (SLOTS),
        .IW    (IW),
        .HALF  (HALF)
    ) issue_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_used     (in_used),
        .in_insn     (in_insn),
        .split       (split),
        .accept      (accept),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_used    (out_used),
        .out_insn    (out_insn),
        .out_dup     (out_dup),
        .out_second  (out_second),
        .fetch_stall (fetch_stall)
    );

endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
    parameter int SLOTS = 8,
    parameter int IW    = 32,
    parameter int HALF  = SLOTS / 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [SLOTS-1:0]     in_used,
    input logic [SLOTS*IW-1:0]  in_insn,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [SLOTS-1:0]     out_used,
    input logic [SLOTS*IW-1:0]  out_insn,
    input logic [HALF-1:0]      out_dup,
    input logic                 out_second,
    input logic                 fetch_stall
);

    // R7
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> !in_ready);

    // R7
    hold_second_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall && !out_ready |=> fetch_stall && out_valid
            && $stable(out_insn) && $stable(out_used));

    // R6
    split_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (|in_used[SLOTS-1:HALF])
            && (out_used[SLOTS-1:HALF] == '0)
        |=> fetch_stall && out_second && out_valid);

    // R6
    second_full_dup_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_second |-> (&out_dup) && (out_used[SLOTS-1:HALF] == '0));

    // R2
    pass_nonqual_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fetch_stall && (in_used[SLOTS-1:HALF] == '0)
        |-> out_valid && (out_used == in_used) && (out_insn == in_insn)
            && (&out_dup) && !out_second);

    // R3
    dup_idle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_second |-> out_dup == ~out_used[SLOTS-1:HALF]);

    // R9
    ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_stall |-> in_ready == out_ready);

endmodule

bind bsplit_top bsplit_chk #(
    .SLOTS (SLOTS),
    .IW    (IW),
    .HALF  (SLOTS / 2)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_used     (in_used),
    .in_insn     (in_insn),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_used    (out_used),
    .out_insn    (out_insn),
    .out_dup     (out_dup),
    .out_second  (out_second),
    .fetch_stall (fetch_stall)
);

// File: tb/bsplit_top_tb_top.sv
module bsplit_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 8;
    localparam int IW         = 32;
    localparam int HALF       = SLOTS / 2;
    localparam int DW         = SLOTS * IW;
    localparam int LW         = HALF * IW;
    localparam int NV         = 16;

    // {thr_we, thr_wdata[7:0], in_used[7:0], expect_split}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 8'd0,  8'h0F, 1'b0},
        {1'b0, 8'd0,  8'h1F, 1'b1},
        {1'b0, 8'd0,  8'hFF, 1'b1},
        {1'b1, 8'd8,  8'h13, 1'b0},
        {1'b0, 8'd0,  8'h03, 1'b0},
        {1'b0, 8'd0,  8'h7F, 1'b1},
        {1'b0, 8'd0,  8'h10, 1'b0},
        {1'b1, 8'd7,  8'h3F, 1'b1},
        {1'b0, 8'd0,  8'h1F, 1'b0},
        {1'b0, 8'd0,  8'h1F, 1'b0},
        {1'b0, 8'd0,  8'hF0, 1'b1},
        {1'b1, 8'd9,  8'hBF, 1'b1},
        {1'b0, 8'd0,  8'h8F, 1'b0},
        {1'b1, 8'd15, 8'hFF, 1'b1},
        {1'b0, 8'd0,  8'hEF, 1'b0},
        {1'b1, 8'd10, 8'h30, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             thr_we;
    logic [7:0]       thr_wdata;
    logic             in_valid;
    logic             in_ready;
    logic [SLOTS-1:0] in_used;
    logic [DW-1:0]    in_insn;
    logic             out_valid;
    logic             out_ready;
    logic [SLOTS-1:0] out_used;
    logic [DW-1:0]    out_insn;
    logic [HALF-1:0]  out_dup;
    logic             out_second;
    logic             fetch_stall;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsplit_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .thr_we      (thr_we),
        .thr_wdata   (thr_wdata),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_used     (in_used),
        .in_insn     (in_insn),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_used    (out_used),
        .out_insn    (out_insn),
        .out_dup     (out_dup),
        .out_second  (out_second),
        .fetch_stall (fetch_stall)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_insn(input int idx);
        logic [DW-1:0] v;
        for (int k = 0; k < SLOTS; k++)
            v[k*IW +: IW] = {idx[15:0], 8'(k), 8'h5A};
        return v;
    endfunction

    task automatic write_thr(input logic [7:0] t);
        @(negedge clk);
        in_valid  = 1'b0;
        thr_we    = 1'b1;
        thr_wdata = t;
        @(negedge clk);
        thr_we    = 1'b0;
    endtask

    // Offers one bundle with out_ready high and checks one or two transfers
    task automatic run_bundle(input int idx, input logic [SLOTS-1:0] used,
                              input logic exp_split, input string req);
        logic [DW-1:0] ins;
        ins = mk_insn(idx);
        @(negedge clk);
        in_valid  = 1'b1;
        in_used   = used;
        in_insn   = ins;
        out_ready = 1'b1;
        #1;
        chk(out_valid && in_ready, {req, " accept"},
            DW'({out_valid, in_ready}), DW'(2'b11));
        if (exp_split) begin
            chk(out_used == {{HALF{1'b0}}, used[HALF-1:0]} && out_dup == '1 && !out_second,
                {req, " R6 first half ctl"}, DW'({out_used, out_dup, out_second}),
                DW'({{HALF{1'b0}}, used[HALF-1:0], {HALF{1'b1}}, 1'b0}));
            chk(out_insn == {{LW{1'b0}}, ins[LW-1:0]}, {req, " R6 first half data"},
                out_insn, {{LW{1'b0}}, ins[LW-1:0]});
        end else begin
            chk(out_used == used && out_dup == ~used[SLOTS-1:HALF] && !out_second,
                {req, " R3 whole ctl"}, DW'({out_used, out_dup, out_second}),
                DW'({used, ~used[SLOTS-1:HALF], 1'b0}));
            chk(out_insn == ins, {req, " whole data"}, out_insn, ins);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (exp_split) begin
            chk(fetch_stall && !in_ready && out_valid && out_second && out_dup == '1,
                {req, " R7 second pending"},
                DW'({fetch_stall, in_ready, out_valid, out_second, out_dup}),
                DW'({1'b1, 1'b0, 1'b1, 1'b1, {HALF{1'b1}}}));
            chk(out_insn == {{LW{1'b0}}, ins[DW-1:LW]}
                && out_used == {{HALF{1'b0}}, used[SLOTS-1:HALF]},
                {req, " R6 second half"}, out_insn, {{LW{1'b0}}, ins[DW-1:LW]});
            @(negedge clk);
            #1;
        end
        chk(!fetch_stall, {req, " no stall after"}, DW'(fetch_stall), DW'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        rst       = 1'b1;
        thr_we    = 1'b0;
        thr_wdata = '0;
        in_valid  = 1'b0;
        in_used   = '0;
        in_insn   = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle state after reset
        chk(!out_valid && !fetch_stall && in_ready, "R1 reset state",
            DW'({out_valid, fetch_stall, in_ready}), DW'(3'b001));

        // Table walk: R1 (default threshold), R2, R3, R4, R5, R8
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][17]) write_thr(VEC[v][16:9]);
            run_bundle(v, VEC[v][8:1], VEC[v][0], $sformatf("R4 vec%0d", v));
        end

        // R7: second half held under backpressure, new bundle not taken
        write_thr(8'd4);
        run_bundle(100, 8'hFF, 1'b1, "R7 setup");
        @(negedge clk);
        in_valid  = 1'b1;
        in_used   = 8'hFF;
        in_insn   = mk_insn(101);
        out_ready = 1'b1;
        #1;
        chk(out_valid && !out_second && out_used == 8'h0F, "R7 prep split",
            DW'({out_valid, out_second, out_used}), DW'({2'b10, 8'h0F}));
        @(negedge clk);
        in_valid  = 1'b1;
        in_insn   = mk_insn(102);
        out_ready = 1'b0;
        #1;
        held = out_insn;
        chk(held == {{LW{1'b0}}, mk_insn(101)[DW-1:LW]}, "R7 held upper",
            held, {{LW{1'b0}}, mk_insn(101)[DW-1:LW]});
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk(fetch_stall && !in_ready && out_valid && out_insn == held,
                "R7 hold stable", out_insn, held);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(!fetch_stall && in_ready, "R7 release",
            DW'({fetch_stall, in_ready}), DW'(2'b01));

        // R9: refused bundle leaves statistic unchanged
        write_thr(8'd8);
        run_bundle(200, 8'h1F, 1'b0, "R9 first");
        @(negedge clk);
        in_valid  = 1'b1;
        in_used   = 8'hF0;
        in_insn   = mk_insn(201);
        out_ready = 1'b0;
        #1;
        chk(!in_ready && out_valid, "R9 ready follows out_ready",
            DW'({in_ready, out_valid}), DW'(2'b01));
        repeat (2) @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        run_bundle(202, 8'h1F, 1'b0, "R9 stats unchanged");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule